// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a pipelined arithmetic slice for inference-style integer math. Each cycle it can accept two 32-bit operands and a 32-bit running total. It splits the operands into packed low-precision lanes and multiplies matching lanes in parallel. It reduces the lane products through a pairwise adder tree and adds the reduced sum into the running total. The new 32-bit total comes out three cycles later.

Two lane geometries share one datapath. In the first, each operand carries four 8-bit lanes. In the second, each operand carries eight 4-bit lanes. One control bit selects how lanes are extended, as two's-complement or as unsigned values. A second control bit selects how the final add behaves: it either wraps modulo 2^32 or clamps to the 32-bit range of the chosen signedness.

Each issue carries its own valid bit, and there is no back-pressure. An upstream issue stage can start one operation per cycle, with or without gaps between them.

Top module: `dot_acc_unit`

## Requirements
- R1: With `mode_i`=0, each operand holds four 8-bit lanes. Lane k occupies bits [8k+7:8k], so lane 0 sits in the least significant byte. The result is `acc_i` plus the sum of the four products a_k*b_k.
- R2: With `mode_i`=1, each operand holds eight 4-bit lanes. Lane k occupies bits [4k+3:4k]. The result is `acc_i` plus the sum of the eight products a_k*b_k.
- R3: With `sign_i`=1, every lane of both operands and `acc_i` are read as two's complement. With `sign_i`=0, all of them are read as unsigned, and the lane-product sum is never negative.
- R4: With `clamp_i`=0, the result is the exact total taken modulo 2^32.
- R5: With `clamp_i`=1 and `sign_i`=1, a total above 0x7FFFFFFF gives 0x7FFFFFFF. A total below -2^31 gives 0x80000000. Any other total is returned exactly.
- R6: With `clamp_i`=1 and `sign_i`=0, a total above 0xFFFFFFFF gives 0xFFFFFFFF. Any other total is returned exactly.
- R7: `valid_o` is high exactly three rising edges after an edge at which `valid_i` was high, and `res_o` then holds that operation's result. Operations may be issued on consecutive cycles, and cycles without `valid_i` give no `valid_o`.
- R8: While `rst_ni` is low, `valid_o` is 0, and operations in flight at that moment never produce `valid_o`.
- R9: The lane-product sum is formed without loss before the add. Four signed -128*-128 products give +65536. In signed 4-bit mode the sum always lies within [-448, 512].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears valid state |
| valid_i | input | 1 | Operation present on the inputs this cycle |
| mode_i | input | 1 | Lane geometry: 0 = four 8-bit lanes, 1 = eight 4-bit lanes |
| sign_i | input | 1 | 1 = two's-complement lanes and total, 0 = unsigned |
| clamp_i | input | 1 | 1 = saturate the final add, 0 = wrap |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| acc_i | input | 32 | Running total to accumulate into |
| valid_o | output | 1 | Result present on `res_o` |
| res_o | output | 32 | Accumulated result |

## Verification
The hardest conditions to reach from the ports are the saturation edges. Uniform random totals land near ±2^31 or 2^32 almost never, and the lane sum can move a total by at most about 2^18. The stimulus therefore draws `acc_i` from windows just inside each clamp limit. It pairs those totals with all-minimum and all-maximum lane patterns, so that totals land exactly on a limit, one past it, and far beyond it. A reset is also applied while the pipeline holds valid operations, to show that those results are dropped.

// File: rtl/dot_acc_pkg.sv
package dot_acc_pkg;
  localparam int DATA_W   = 32;
  localparam int WIDE_W   = 8;
  localparam int NARROW_W = 4;
  localparam int N_LANES  = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;
  localparam int EXT_W    = WIDE_W + 1;
  localparam int PROD_W   = 2 * EXT_W;
  localparam int SUM_W    = PROD_W + $clog2(N_LANES);
  localparam int TOT_W    = DATA_W + 2;

  typedef struct packed {
    logic narrow;
    logic sgn;
    logic clamp;
  } ctrl_t;

  function automatic logic signed [EXT_W-1:0] ext_narrow(logic [NARROW_W-1:0] v, logic s);
    return {{(EXT_W-NARROW_W){s & v[NARROW_W-1]}}, v};
  endfunction

  function automatic logic signed [EXT_W-1:0] ext_wide(logic [WIDE_W-1:0] v, logic s);
    return {{(EXT_W-WIDE_W){s & v[WIDE_W-1]}}, v};
  endfunction
endpackage

// File: rtl/dot_lane_mul.sv
module dot_lane_mul
  import dot_acc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  ctrl_t                     ctrl_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  input  logic [DATA_W-1:0]         acc_i,
  output logic                      valid_o,
  output ctrl_t                     ctrl_o,
  output logic [DATA_W-1:0]         acc_o,
  output logic [N_LANES*PROD_W-1:0] prod_o
);
  logic [N_LANES*PROD_W-1:0] prod_d;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic signed [EXT_W-1:0]  ea, eb;
    logic signed [PROD_W-1:0] p;
    if (g < N_WIDE) begin : g_dual
      always_comb begin
        if (ctrl_i.narrow) begin
          ea = ext_narrow(a_i[g*NARROW_W +: NARROW_W], ctrl_i.sgn);
          eb = ext_narrow(b_i[g*NARROW_W +: NARROW_W], ctrl_i.sgn);
        end else begin
          ea = ext_wide(a_i[g*WIDE_W +: WIDE_W], ctrl_i.sgn);
          eb = ext_wide(b_i[g*WIDE_W +: WIDE_W], ctrl_i.sgn);
        end
      end
    end else begin : g_nar
      // upper lanes exist only in narrow mode
      always_comb begin
        if (ctrl_i.narrow) begin
          ea = ext_narrow(a_i[g*NARROW_W +: NARROW_W], ctrl_i.sgn);
          eb = ext_narrow(b_i[g*NARROW_W +: NARROW_W], ctrl_i.sgn);
        end else begin
          ea = '0;
          eb = '0;
        end
      end
    end
    assign p = ea * eb;
    assign prod_d[g*PROD_W +: PROD_W] = p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    ctrl_o <= ctrl_i;
    acc_o  <= acc_i;
    prod_o <= prod_d;
  end
endmodule

// File: rtl/dot_reduce.sv
module dot_reduce
  import dot_acc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  ctrl_t                     ctrl_i,
  input  logic [DATA_W-1:0]         acc_i,
  input  logic [N_LANES*PROD_W-1:0] prod_i,
  output logic                      valid_o,
  output ctrl_t                     ctrl_o,
  output logic [DATA_W-1:0]         acc_o,
  output logic signed [SUM_W-1:0]   sum_o
);
  logic signed [SUM_W-1:0] node [N_LANES];

  // pairwise tree, stride doubles per level
  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      node[i] = {{(SUM_W-PROD_W){prod_i[i*PROD_W+PROD_W-1]}}, prod_i[i*PROD_W +: PROD_W]};
    end
    for (int s = 1; s < N_LANES; s = s * 2) begin
      for (int n = 0; n + s < N_LANES; n = n + 2 * s) begin
        node[n] = node[n] + node[n+s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    ctrl_o <= ctrl_i;
    acc_o  <= acc_i;
    sum_o  <= node[0];
  end

  // R3
  unsigned_sum_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ctrl_o.sgn |-> !sum_o[SUM_W-1]);
endmodule

// File: rtl/dot_accum.sv
module dot_accum
  import dot_acc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  ctrl_t                   ctrl_i,
  input  logic [DATA_W-1:0]       acc_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       res_o
);
  localparam logic signed [TOT_W-1:0] S_MAX = {{(TOT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [TOT_W-1:0] S_MIN = {{(TOT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] R_SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] R_SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int N_MAXP = N_LANES * (2 ** (2 * (NARROW_W - 1)));
  localparam int N_MINP = -N_LANES * (2 ** (NARROW_W - 1)) * (2 ** (NARROW_W - 1) - 1);

  logic signed [TOT_W-1:0] acc_x, sum_x, tot;
  logic [DATA_W-1:0]       res_d;

  always_comb begin
    acc_x = ctrl_i.sgn ? {{(TOT_W-DATA_W){acc_i[DATA_W-1]}}, acc_i}
                       : {{(TOT_W-DATA_W){1'b0}}, acc_i};
    sum_x = {{(TOT_W-SUM_W){sum_i[SUM_W-1]}}, sum_i};
    tot   = acc_x + sum_x;
    if (!ctrl_i.clamp) begin
      res_d = tot[DATA_W-1:0];
    end else if (ctrl_i.sgn) begin
      if (tot > S_MAX)      res_d = R_SMAX;
      else if (tot < S_MIN) res_d = R_SMIN;
      else                  res_d = tot[DATA_W-1:0];
    end else begin
      res_d = (tot[TOT_W-1:DATA_W] != '0) ? '1 : tot[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) res_o <= res_d;

  // R9
  narrow_sum_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ctrl_i.narrow && ctrl_i.sgn |-> (sum_i <= N_MAXP) && (sum_i >= N_MINP));
  // R5
  sat_signed_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ctrl_i.clamp && ctrl_i.sgn && !sum_i[SUM_W-1]
    |=> $signed(res_o) >= $signed($past(acc_i)));
  // R5
  sat_signed_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ctrl_i.clamp && ctrl_i.sgn && sum_i[SUM_W-1]
    |=> $signed(res_o) <= $signed($past(acc_i)));
  // R6
  sat_unsigned_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ctrl_i.clamp && !ctrl_i.sgn |=> res_o >= $past(acc_i));
endmodule

// File: rtl/dot_acc_unit.sv
module dot_acc_unit
  import dot_acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              sign_i,
  input  logic              clamp_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  ctrl_t                     ctrl_in, ctrl_s1, ctrl_s2;
  logic                      v_s1, v_s2;
  logic [DATA_W-1:0]         acc_s1, acc_s2;
  logic [N_LANES*PROD_W-1:0] prod_s1;
  logic signed [SUM_W-1:0]   sum_s2;

  assign ctrl_in = '{narrow: mode_i, sgn: sign_i, clamp: clamp_i};

  dot_lane_mul u_mul (
    .clk_i, .rst_ni, .valid_i, .ctrl_i(ctrl_in), .a_i, .b_i, .acc_i,
    .valid_o(v_s1), .ctrl_o(ctrl_s1), .acc_o(acc_s1), .prod_o(prod_s1)
  );

  dot_reduce u_red (
    .clk_i, .rst_ni, .valid_i(v_s1), .ctrl_i(ctrl_s1), .acc_i(acc_s1), .prod_i(prod_s1),
    .valid_o(v_s2), .ctrl_o(ctrl_s2), .acc_o(acc_s2), .sum_o(sum_s2)
  );

  dot_accum u_acc (
    .clk_i, .rst_ni, .valid_i(v_s2), .ctrl_i(ctrl_s2), .acc_i(acc_s2), .sum_i(sum_s2),
    .valid_o, .res_o
  );

  // edges seen since reset, caps at pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst == 2'd3 |-> valid_o == $past(valid_i, 3));
endmodule

// File: tb/dot_acc_unit_tb.sv
module dot_acc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, mode_i = 1'b0, sign_i = 1'b0, clamp_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, acc_i = '0;
  logic        valid_o;
  logic [31:0] res_o;

  int n_run = 0, n_fail = 0;
  bit          pv [3];
  logic [31:0] pr [3];
  string       pt [3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dot_acc_unit u_dut (.*);

  function automatic logic [31:0] model(bit m, bit s, bit c, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] acc);
    longint sum = 0, tot, x, y;
    int w = m ? 4 : 8;
    for (int i = 0; i < 32 / w; i++) begin
      x = longint'((a >> (i * w)) & ((32'd1 << w) - 1));
      y = longint'((b >> (i * w)) & ((32'd1 << w) - 1));
      if (s && x >= (longint'(1) << (w - 1))) x -= (longint'(1) << w);
      if (s && y >= (longint'(1) << (w - 1))) y -= (longint'(1) << w);
      sum += x * y;
    end
    tot = s ? longint'($signed(acc)) : longint'({32'b0, acc});
    tot += sum;
    if (!c) return tot[31:0];
    if (s) begin
      if (tot > 64'sh7fffffff) return 32'h7fffffff;
      if (tot < -64'sh80000000) return 32'h80000000;
      return tot[31:0];
    end
    if (tot > 64'shffffffff) return 32'hffffffff;
    return tot[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge: check the op issued three steps back, then issue
  task automatic step(bit v, bit m, bit s, bit c, logic [31:0] a, logic [31:0] b,
                      logic [31:0] acc, string tag);
    chk("R7 valid", {31'b0, valid_o}, {31'b0, pv[2]});
    if (pv[2]) chk(pt[2], res_o, pr[2]);
    pv[2] = pv[1]; pr[2] = pr[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    pv[0] = v; pr[0] = model(m, s, c, a, b, acc); pt[0] = tag;
    valid_i = v; mode_i = m; sign_i = s; clamp_i = c;
    a_i = a; b_i = b; acc_i = acc;
    @(negedge clk_i);
  endtask

  task automatic op(bit m, bit s, bit c, logic [31:0] a, logic [31:0] b, logic [31:0] acc,
                    string tag);
    step(1'b1, m, s, c, a, b, acc, tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, "idle");
  endtask

  function automatic logic [31:0] rnd_op(int kind);
    case (kind)
      0: return 32'h80808080;
      1: return 32'h7f7f7f7f;
      2: return 32'hffffffff;
      3: return 32'h88888888;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] rnd_acc();
    case ($urandom_range(0, 4))
      0: return 32'h7fff0000 + ($urandom & 32'hffff);
      1: return 32'h80000000 + ($urandom & 32'hffff);
      2: return 32'hfffc0000 + ($urandom & 32'h3ffff);
      3: return $urandom & 32'h3ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7351));
    for (int i = 0; i < 3; i++) begin pv[i] = 0; pr[i] = '0; pt[i] = ""; end
    #1;
    chk("R8 reset", {31'b0, valid_o}, 32'd0);
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 reset held", {31'b0, valid_o}, 32'd0);
    rst_ni = 1'b1;

    // lane placement
    op(1'b0, 1'b0, 1'b0, 32'h0000_0102, 32'h0000_0300, 32'd0, "R1 lane order");
    op(1'b0, 1'b0, 1'b0, 32'h0403_0201, 32'h0101_0101, 32'd100, "R1 byte lanes");
    op(1'b1, 1'b0, 1'b0, 32'h8765_4321, 32'h1111_1111, 32'd0, "R2 nibble lanes");
    op(1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'h0000_0003, 32'd5, "R2 lane order");
    // signedness
    op(1'b0, 1'b1, 1'b0, 32'hffff_ffff, 32'h0101_0101, 32'd0, "R3 signed -1");
    op(1'b0, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 32'd0, "R3 unsigned max");
    op(1'b1, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 32'd0, "R3 nibble unsigned max");
    op(1'b1, 1'b1, 1'b0, 32'hffff_ffff, 32'h7777_7777, 32'd0, "R3 nibble signed");
    // exact sums at extremes
    op(1'b0, 1'b1, 1'b0, 32'h8080_8080, 32'h8080_8080, 32'd0, "R9 all-min bytes");
    op(1'b1, 1'b1, 1'b0, 32'h8888_8888, 32'h8888_8888, 32'd0, "R9 all-min nibbles");
    op(1'b1, 1'b1, 1'b0, 32'h8888_8888, 32'h7777_7777, 32'd0, "R9 min*max nibbles");
    // wrap
    op(1'b0, 1'b1, 1'b0, 32'h8080_8080, 32'h8080_8080, 32'h7fff_ff00, "R4 signed wrap");
    op(1'b0, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ff00, "R4 unsigned wrap");
    // signed saturation
    op(1'b0, 1'b1, 1'b1, 32'h8080_8080, 32'h8080_8080, 32'h7fff_ff00, "R5 clamp high");
    op(1'b0, 1'b1, 1'b1, 32'h8080_8080, 32'h8080_8080, 32'h7ffe_ffff, "R5 exact max");
    op(1'b0, 1'b1, 1'b1, 32'h8080_8080, 32'h8080_8080, 32'h7fff_0000, "R5 one past max");
    op(1'b0, 1'b1, 1'b1, 32'h8080_8080, 32'h7f7f_7f7f, 32'h8000_0010, "R5 clamp low");
    op(1'b0, 1'b1, 1'b1, 32'h8080_8080, 32'h7f7f_7f7f, 32'h8000_fe00, "R5 exact min");
    // unsigned saturation
    op(1'b0, 1'b0, 1'b1, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ff00, "R6 clamp");
    op(1'b0, 1'b0, 1'b1, 32'hffff_ffff, 32'hffff_ffff, 32'hfffc_07fb, "R6 exact max");
    op(1'b1, 1'b0, 1'b1, 32'hffff_ffff, 32'hffff_ffff, 32'h8000_0000, "R6 no clamp needed");
    flush();

    // reset with operations in flight
    op(1'b0, 1'b0, 1'b0, 32'h0101_0101, 32'h0101_0101, 32'd1, "R8 in flight");
    op(1'b0, 1'b0, 1'b0, 32'h0101_0101, 32'h0101_0101, 32'd2, "R8 in flight");
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R8 mid-run reset", {31'b0, valid_o}, 32'd0);
    for (int i = 0; i < 3; i++) pv[i] = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    flush();

    // random mix, bubbles included
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom_range(0, 9) < 8);
      bit m = $urandom_range(0, 1) != 0;
      bit s = $urandom_range(0, 1) != 0;
      bit c = $urandom_range(0, 1) != 0;
      logic [31:0] a = rnd_op($urandom_range(0, 9));
      logic [31:0] b = rnd_op($urandom_range(0, 9));
      step(v, m, s, c, a, b, rnd_acc(), m ? "R2 random" : "R1 random");
    end
    flush();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule